// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Unit

This unit carries out the memory half of load and store instructions for a 32-bit core. Each request brings a decoded 6-bit opcode, a base register value, a 16-bit displacement, the value of the register to be stored, and the index of the register to be loaded. The unit forms the effective byte address from the base and the sign-extended displacement. It drives a word address to a 32-bit little-endian data memory, with one write strobe per byte lane. It steers store data onto those lanes. When the read data comes back, it picks and extends the loaded value for write-back.

Five operations are supported: whole-word load and store, signed and unsigned byte load, and byte store. A word access whose address is not a multiple of four is refused: an error flag is raised and no memory access is made. The memory answers a read in the cycle after the request. Only one access is in flight at a time, but a new request may be issued every cycle.

Top module: `mem_access_unit`

## Requirements
- R1: The effective address is base_val plus offset sign-extended from bit 15, modulo 2^32. mem_addr carries effective-address bits 31:2 in the same cycle as the request.
- R2: Opcode 35 (word load) at an address whose bits 1:0 are zero asserts mem_req with mem_we all zero. In the next cycle ld_valid is high for that request, ld_data equals mem_rdata and ld_dest equals the dest_idx of the request.
- R3: Opcode 32 (signed byte load) returns the byte in lane n = address bits 1:0, which is mem_rdata bits 8n+7:8n. Bits 31:8 of ld_data are copies of bit 7 of that byte.
- R4: Opcode 36 (unsigned byte load) returns the same lane byte with bits 31:8 of ld_data cleared.
- R5: Opcode 43 (word store) at an address whose bits 1:0 are zero asserts mem_req with mem_we = 4'b1111 and mem_wdata = store_val. It produces no load result.
- R6: Opcode 40 (byte store) asserts mem_req with only mem_we bit n set, where n is address bits 1:0. Bits 7:0 of store_val appear on all four byte lanes of mem_wdata, so only byte n of the word changes.
- R7: A word load or word store whose address bits 1:0 are non-zero raises align_err in the request cycle. It keeps mem_req low and mem_we zero, leaves memory unchanged and produces no ld_valid.
- R8: While req_valid is low, or when the opcode is none of 32, 35, 36, 40 and 43, mem_req, mem_we and align_err stay zero and no load result follows.
- R9: While rst_n is low, and in the first cycle after it rises, ld_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| opcode | input | 6 | Decoded primary opcode |
| base_val | input | 32 | Base register value |
| offset | input | 16 | Signed displacement field |
| store_val | input | 32 | Value of the register to be stored |
| dest_idx | input | 5 | Destination register index for loads |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |
| mem_req | output | 1 | Memory access this cycle |
| mem_addr | output | 30 | Word address (effective address bits 31:2) |
| mem_we | output | 4 | Byte-lane write strobes, bit n for bits 8n+7:8n |
| mem_wdata | output | 32 | Store data steered onto the lanes |
| align_err | output | 1 | Misaligned word access refused |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Extended load result |
| ld_dest | output | 5 | Register index for the load result |

## Verification
The address, the write strobes, the write data and the alignment error are combinational, so they are due in the request cycle itself. The bench drives each request just after a falling edge and samples these outputs 1 ns later, before the next rising edge. A load result is due exactly one cycle later, in the cycle between the rising edge that captures the read and the following one. The driver queues the expected value and register index at issue time, using its own model of memory. A monitor pops one entry on every falling edge at which ld_valid is high, so a result that comes late, comes early, comes twice or never comes shows up as a mismatch or as a queue that is not empty at the end.

// File: rtl/mau_pkg.sv
package mau_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LD_WORD  = 6'd35;
  localparam logic [OPC_W-1:0] OPC_LD_BYTE  = 6'd32;
  localparam logic [OPC_W-1:0] OPC_LD_UBYTE = 6'd36;
  localparam logic [OPC_W-1:0] OPC_ST_BYTE  = 6'd40;
  localparam logic [OPC_W-1:0] OPC_ST_WORD  = 6'd43;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_BYTE = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      known;
    logic      is_load;
    logic      sign_ext;
    acc_size_e size;
  } op_info_t;

  function automatic op_info_t decode_op(input logic [OPC_W-1:0] op);
    op_info_t d;
    d = '{known: 1'b0, is_load: 1'b0, sign_ext: 1'b0, size: SZ_NONE};
    case (op)
      OPC_LD_WORD:  d = '{known: 1'b1, is_load: 1'b1, sign_ext: 1'b0, size: SZ_WORD};
      OPC_LD_BYTE:  d = '{known: 1'b1, is_load: 1'b1, sign_ext: 1'b1, size: SZ_BYTE};
      OPC_LD_UBYTE: d = '{known: 1'b1, is_load: 1'b1, sign_ext: 1'b0, size: SZ_BYTE};
      OPC_ST_WORD:  d = '{known: 1'b1, is_load: 1'b0, sign_ext: 1'b0, size: SZ_WORD};
      OPC_ST_BYTE:  d = '{known: 1'b1, is_load: 1'b0, sign_ext: 1'b0, size: SZ_BYTE};
      default:      d = '{known: 1'b0, is_load: 1'b0, sign_ext: 1'b0, size: SZ_NONE};
    endcase
    return d;
  endfunction

  // Widen a displacement to address width by copying its top bit.
  function automatic logic [31:0] widen_signed16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

endpackage

// File: rtl/mau_addr_gen.sv
module mau_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 16,
  parameter int LANE_BITS = 2
) (
  input  logic [ADDR_W-1:0]           base_val,
  input  logic [OFS_W-1:0]            offset,
  output logic [ADDR_W-LANE_BITS-1:0] word_addr,
  output logic [LANE_BITS-1:0]        lane
);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] eff_addr;

  assign disp      = {{EXT_W{offset[OFS_W-1]}}, offset};
  assign eff_addr  = base_val + disp;
  assign word_addr = eff_addr[ADDR_W-1:LANE_BITS];
  assign lane      = eff_addr[LANE_BITS-1:0];
endmodule

// File: rtl/mau_store_lanes.sv
module mau_store_lanes #(
  parameter int DATA_W    = 32,
  parameter int LANE_BITS = 2
) (
  input  logic                 enable,
  input  logic                 whole_word,
  input  logic [LANE_BITS-1:0] lane,
  input  logic [DATA_W-1:0]    store_val,
  output logic [DATA_W/8-1:0]  we,
  output logic [DATA_W-1:0]    wdata
);
  localparam int LANES = DATA_W / 8;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    assign we[gi] = enable && (whole_word || (lane == LANE_BITS'(gi)));
    assign wdata[8*gi +: 8] = whole_word ? store_val[8*gi +: 8] : store_val[7:0];
  end
endmodule

// File: rtl/mau_load_extract.sv
module mau_load_extract #(
  parameter int DATA_W    = 32,
  parameter int LANE_BITS = 2
) (
  input  logic [DATA_W-1:0]    rdata,
  input  logic [LANE_BITS-1:0] lane,
  input  logic                 is_byte,
  input  logic                 sign_ext,
  output logic [DATA_W-1:0]    result
);
  localparam int LANES = DATA_W / 8;

  logic [7:0] lane_bytes [LANES];
  logic [7:0] picked;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_split
    assign lane_bytes[gi] = rdata[8*gi +: 8];
  end

  always_comb begin
    picked = lane_bytes[lane];
    if (is_byte) begin
      result = {{(DATA_W-8){sign_ext & picked[7]}}, picked};
    end else begin
      result = rdata;
    end
  end
endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int OFS_W     = 16,
  parameter int REG_IDX_W = 5,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [mau_pkg::OPC_W-1:0]      opcode,
  input  logic [ADDR_W-1:0]              base_val,
  input  logic [OFS_W-1:0]               offset,
  input  logic [DATA_W-1:0]              store_val,
  input  logic [REG_IDX_W-1:0]           dest_idx,
  input  logic [DATA_W-1:0]              mem_rdata,
  output logic                           mem_req,
  output logic [ADDR_W-LANE_BITS-1:0]    mem_addr,
  output logic [LANES-1:0]               mem_we,
  output logic [DATA_W-1:0]              mem_wdata,
  output logic                           align_err,
  output logic                           ld_valid,
  output logic [DATA_W-1:0]              ld_data,
  output logic [REG_IDX_W-1:0]           ld_dest
);
  import mau_pkg::*;

  // Named internal events, visible to the bound checker.
  op_info_t               dec_info;
  logic [LANE_BITS-1:0]   req_lane;
  logic                   word_misaligned;
  logic                   access_go;
  logic                   ld_is_byte;
  logic                   ld_is_signed;

  logic                   pend_valid;
  logic [LANE_BITS-1:0]   pend_lane;
  logic [REG_IDX_W-1:0]   pend_dest;

  assign dec_info = decode_op(opcode);

  mau_addr_gen #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .LANE_BITS(LANE_BITS)
  ) u_addr (
    .base_val (base_val),
    .offset   (offset),
    .word_addr(mem_addr),
    .lane     (req_lane)
  );

  assign word_misaligned = (dec_info.size == SZ_WORD) && (req_lane != '0);
  assign access_go       = req_valid && dec_info.known && !word_misaligned;
  assign align_err       = req_valid && dec_info.known && word_misaligned;
  assign mem_req         = access_go;

  mau_store_lanes #(
    .DATA_W(DATA_W), .LANE_BITS(LANE_BITS)
  ) u_store (
    .enable    (access_go && !dec_info.is_load),
    .whole_word(dec_info.size == SZ_WORD),
    .lane      (req_lane),
    .store_val (store_val),
    .we        (mem_we),
    .wdata     (mem_wdata)
  );

  // One outstanding load: remember how to shape the returning word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid   <= 1'b0;
      pend_lane    <= '0;
      pend_dest    <= '0;
      ld_is_byte   <= 1'b0;
      ld_is_signed <= 1'b0;
    end else begin
      pend_valid <= access_go && dec_info.is_load;
      if (access_go && dec_info.is_load) begin
        pend_lane    <= req_lane;
        pend_dest    <= dest_idx;
        ld_is_byte   <= (dec_info.size == SZ_BYTE);
        ld_is_signed <= dec_info.sign_ext;
      end
    end
  end

  mau_load_extract #(
    .DATA_W(DATA_W), .LANE_BITS(LANE_BITS)
  ) u_load (
    .rdata   (mem_rdata),
    .lane    (pend_lane),
    .is_byte (ld_is_byte),
    .sign_ext(ld_is_signed),
    .result  (ld_data)
  );

  assign ld_valid = pend_valid;
  assign ld_dest  = pend_dest;
endmodule

// File: rtl/mau_checker.sv
module mau_checker #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [mau_pkg::OPC_W-1:0] opcode,
  input logic [DATA_W-1:0]         store_val,
  input logic                      mem_req,
  input logic [LANES-1:0]          mem_we,
  input logic [DATA_W-1:0]         mem_wdata,
  input logic                      align_err,
  input logic                      ld_valid,
  input logic [DATA_W-1:0]         ld_data,
  input logic                      ld_is_byte,
  input logic                      ld_is_signed
);
  import mau_pkg::*;

  logic op_is_load;
  assign op_is_load = (opcode == OPC_LD_WORD) || (opcode == OPC_LD_BYTE) ||
                      (opcode == OPC_LD_UBYTE);

  AST_LOAD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && op_is_load) |-> (mem_we == '0)); // R2

  AST_RESULT_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_req && (mem_we == '0))); // R2

  AST_SBYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_is_byte && ld_is_signed) |->
      (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}})); // R3

  AST_UBYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_is_byte && !ld_is_signed) |-> (ld_data[DATA_W-1:8] == '0)); // R4

  AST_WORD_STORE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && opcode == OPC_ST_WORD) |->
      ((mem_we == '1) && (mem_wdata == store_val))); // R5

  AST_BYTE_STORE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && opcode == OPC_ST_BYTE) |-> ($countones(mem_we) == 1)); // R6

  AST_MISALIGN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_req && (mem_we == '0))); // R7

  AST_MISALIGN_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (align_err && !mem_req) |=> !ld_valid); // R7
endmodule

bind mem_access_unit mau_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .opcode      (opcode),
  .store_val   (store_val),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_wdata   (mem_wdata),
  .align_err   (align_err),
  .ld_valid    (ld_valid),
  .ld_data     (ld_data),
  .ld_is_byte  (ld_is_byte),
  .ld_is_signed(ld_is_signed)
);

// File: tb/mem_access_unit_tb_top.sv
`timescale 1ns/1ps
module mem_access_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  opcode = '0;
  logic [31:0] base_val = '0;
  logic [15:0] offset = '0;
  logic [31:0] store_val = '0;
  logic [4:0]  dest_idx = '0;
  logic [31:0] mem_rdata;
  logic        mem_req;
  logic [29:0] mem_addr;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;
  logic        align_err;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic [4:0]  ld_dest;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mem_access_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
    .base_val(base_val), .offset(offset), .store_val(store_val),
    .dest_idx(dest_idx), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .align_err(align_err), .ld_valid(ld_valid), .ld_data(ld_data),
    .ld_dest(ld_dest)
  );

  // Memory the design talks to, and an independent model of its contents.
  logic [31:0] ram     [16];
  logic [31:0] ref_mem [16];
  logic [31:0] rdata_q = '0;
  assign mem_rdata = rdata_q;

  initial begin
    for (int i = 0; i < 16; i++) begin
      ram[i]     = 32'h9C5A_1E00 ^ (i * 32'h0111_2113);
      ref_mem[i] = 32'h9C5A_1E00 ^ (i * 32'h0111_2113);
    end
  end

  always @(posedge clk) begin
    if (mem_req) begin
      for (int b = 0; b < 4; b++)
        if (mem_we[b]) ram[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      rdata_q <= ram[mem_addr[3:0]];
    end
  end

  // Scoreboard of expected load results.
  logic [31:0] q_data [$];
  logic [4:0]  q_dest [$];
  string       q_tag  [$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ld_valid) begin
      if (q_data.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R7/R8 unexpected load result actual=%h expected=none", ld_data);
      end else begin
        logic [31:0] ed;
        logic [4:0]  er;
        string       et;
        ed = q_data.pop_front();
        er = q_dest.pop_front();
        et = q_tag.pop_front();
        chk({et, " ld_data"}, ld_data, ed);
        chk({et, " ld_dest"}, 32'(ld_dest), 32'(er));
      end
    end
  end

  task automatic issue(input logic [5:0] op, input logic [31:0] base,
                       input logic [15:0] ofs, input logic [31:0] sval,
                       input logic [4:0] dst, input string ltag);
    logic [31:0] ea;
    logic [31:0] w;
    logic [7:0]  bt;
    logic [1:0]  ln;
    logic [3:0]  ix;
    bit known, is_word, mis, is_ld;
    @(negedge clk);
    req_valid = 1'b1;
    opcode    = op;
    base_val  = base;
    offset    = ofs;
    store_val = sval;
    dest_idx  = dst;
    ea      = base + {{16{ofs[15]}}, ofs};
    ln      = ea[1:0];
    ix      = ea[5:2];
    known   = (op == 6'd35) || (op == 6'd32) || (op == 6'd36) || (op == 6'd43) || (op == 6'd40);
    is_word = (op == 6'd35) || (op == 6'd43);
    is_ld   = (op == 6'd35) || (op == 6'd32) || (op == 6'd36);
    mis     = is_word && (ln != 2'd0);
    #1;
    chk(known ? "R7 align_err" : "R8 align_err", 32'(align_err), 32'(known && mis));
    chk(known ? "R7 mem_req" : "R8 mem_req", 32'(mem_req), 32'(known && !mis));
    if (known && !mis) begin
      chk("R1 mem_addr", 32'(mem_addr), 32'(ea[31:2]));
      if (is_ld) begin
        chk("R2 load mem_we", 32'(mem_we), 32'd0);
        w  = ref_mem[ix];
        bt = w[8*ln +: 8];
        if (op == 6'd35)      q_data.push_back(w);
        else if (op == 6'd32) q_data.push_back({{24{bt[7]}}, bt});
        else                  q_data.push_back({24'd0, bt});
        q_dest.push_back(dst);
        q_tag.push_back(ltag);
      end else if (op == 6'd43) begin
        chk("R5 mem_we", 32'(mem_we), 32'hF);
        chk("R5 mem_wdata", mem_wdata, sval);
        ref_mem[ix] = sval;
      end else begin
        chk("R6 mem_we", 32'(mem_we), 32'(4'b0001 << ln));
        chk("R6 mem_wdata", mem_wdata, {4{sval[7:0]}});
        ref_mem[ix][8*ln +: 8] = sval[7:0];
      end
    end else begin
      chk(known ? "R7 mem_we" : "R8 mem_we", 32'(mem_we), 32'd0);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      opcode    = '0;
    end
  endtask

  // R8: opcode of a load with req_valid low, and a misaligned address on top.
  task automatic quiet_probe();
    @(negedge clk);
    req_valid = 1'b0;
    opcode    = 6'd35;
    base_val  = 32'h0000_0002;
    offset    = 16'h0000;
    #1;
    chk("R8 idle mem_req", 32'(mem_req), 32'd0);
    chk("R8 idle mem_we", 32'(mem_we), 32'd0);
    chk("R8 idle align_err", 32'(align_err), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9 ld_valid in reset", 32'(ld_valid), 32'd0);
    chk("R9 mem_req in reset", 32'(mem_req), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R9 ld_valid after reset", 32'(ld_valid), 32'd0);

    // Word loads: aligned, negative displacement, wrap past 2^32.
    issue(6'd35, 32'h1000_0000, 16'h0008, 32'h0, 5'd4,  "R2 lw");
    issue(6'd35, 32'h0000_0020, 16'hFFF8, 32'h0, 5'd14, "R1 lw negative offset");
    issue(6'd35, 32'hFFFF_FFF0, 16'h0020, 32'h0, 5'd7,  "R1 lw wrap");
    idle(2);

    // Word store, then read it back.
    issue(6'd43, 32'h0000_0100, 16'h000C, 32'hDEAD_BEEF, 5'd0, "R5");
    issue(6'd35, 32'h0000_0100, 16'h000C, 32'h0, 5'd9, "R5 lw readback");
    idle(2);

    // Byte stores into each lane of one word, then read the word back.
    issue(6'd40, 32'h0000_0010, 16'h0000, 32'h1234_5681, 5'd0, "R6");
    issue(6'd40, 32'h0000_0010, 16'h0001, 32'hFFFF_FF7F, 5'd0, "R6");
    issue(6'd40, 32'h0000_0014, 16'hFFFE, 32'h0000_00C3, 5'd0, "R6");
    issue(6'd40, 32'h0000_0013, 16'h0000, 32'hAAAA_AA05, 5'd0, "R6");
    issue(6'd35, 32'h0000_0010, 16'h0000, 32'h0, 5'd3, "R6 lw readback");
    idle(1);

    // Byte loads from every lane, signed and unsigned, back to back.
    for (int l = 0; l < 4; l++) begin
      issue(6'd32, 32'h0000_0010, 16'(l), 32'h0, 5'(l + 16), "R3 lb");
      issue(6'd36, 32'h0000_0010, 16'(l), 32'h0, 5'(l + 20), "R4 lbu");
    end
    issue(6'd32, 32'h0000_0040, 16'h0005, 32'h0, 5'd30, "R3 lb positive");
    issue(6'd36, 32'h0000_0040, 16'h0006, 32'h0, 5'd31, "R4 lbu");
    idle(2);

    // Misaligned word accesses are refused; memory must be unchanged.
    issue(6'd35, 32'h0000_0020, 16'h0002, 32'h0, 5'd5, "R7");
    issue(6'd43, 32'h0000_0020, 16'h0001, 32'h0BAD_F00D, 5'd0, "R7");
    issue(6'd43, 32'h0000_0023, 16'h0000, 32'h0BAD_F00D, 5'd0, "R7");
    idle(1);
    issue(6'd35, 32'h0000_0020, 16'h0000, 32'h0, 5'd6, "R7 memory unchanged");
    idle(2);

    // Opcodes outside the five, and no request.
    issue(6'd8,  32'h0000_0010, 16'h0000, 32'h5555_5555, 5'd8, "R8");
    issue(6'd41, 32'h0000_0010, 16'h0000, 32'h5555_5555, 5'd8, "R8");
    quiet_probe();
    idle(1);
    issue(6'd35, 32'h0000_0010, 16'h0000, 32'h0, 5'd10, "R8 memory unchanged");
    idle(3);

    chk("R2 all load results delivered", 32'(q_data.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule